// File: doc/BRIEF.md
# 64-bit Global Timer with Self-Stepping Comparator

This block keeps a 64-bit up-counter that advances at the clock rate divided by a programmable 8-bit prescaler. Software sees the counter as two 32-bit words, a low half and a high half. A 64-bit compare value and a 32-bit step value sit beside the counter. When compare is switched on and the counter has reached or passed the compare value, a sticky event flag is set. That flag drives an interrupt line when interrupts are enabled.

With auto-stepping switched on, every match adds the step value to the compare value. Software loads the first deadline and the period once, and the block then produces a regular series of events with no further writes.

Register access is a plain single-cycle bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The bus carries no stream, so it has no valid/ready handshake and never applies back-pressure.

Top module: `gtc_timer64`

## Requirements
- R1: Register offsets: 0x00 counter low, 0x04 counter high, 0x08 control, 0x0C status, 0x10 compare low, 0x14 compare high, 0x18 step. The control fields are run at bit 0, compare enable at bit 1, interrupt enable at bit 2, auto-step at bit 3 and prescaler at bits 15:8. Control reads back only these fields, with all other bits zero. Compare and step read back the values written.
- R2: While run is 1, the counter rises by exactly one every (prescaler + 1) clock cycles. While run is 0, it holds its value.
- R3: The counter is one 64-bit value: a step from 0xFFFFFFFF in the low half clears the low half and adds one to the high half.
- R4: Writes to the counter halves take effect only while run is 0. While run is 1 they are ignored.
- R5: When compare enable is 1 and counter >= compare value, status bit 0 is set on the next edge. When compare enable is 0, no match occurs.
- R6: Writing 1 to status bit 0 clears the flag. If the match condition still holds, the flag stays set.
- R7: When auto-step is 1, each cycle with a match adds the step value to the compare value.
- R8: When auto-step is 0, the compare value changes only when the bus writes it.
- R9: `irq` is high exactly when status bit 0 is 1 and interrupt enable is 1.
- R10: After reset, every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, level |

## Verification
On every cycle, the bound assertions check the following:
- the counter never jumps by more than one while running, and holds while stopped;
- a match sets the flag on the next edge;
- each auto-step adds exactly the step value, and the compare value holds when auto-step is off;
- `irq` never rises while interrupts are disabled.

The exact prescaler period, the carry across the half boundary, the ignored counter write while running, the write-one-to-clear behaviour and the value at which the auto-stepping compare settles can only be shown by the bench's directed scenarios.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  parameter int unsigned REG_AW = 5;
  parameter int unsigned PRESC_W = 8;

  localparam logic [REG_AW-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_STAT   = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CMP_LO = 5'h10;
  localparam logic [REG_AW-1:0] OFS_CMP_HI = 5'h14;
  localparam logic [REG_AW-1:0] OFS_STEP   = 5'h18;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               ainc;
    logic               irq_en;
    logic               cmp_en;
    logic               run;
  } gtc_ctrl_t;

  function automatic gtc_ctrl_t ctrl_unpack(input logic [31:0] w);
    gtc_ctrl_t c;
    c.presc  = w[8 +: PRESC_W];
    c.ainc   = w[3];
    c.irq_en = w[2];
    c.cmp_en = w[1];
    c.run    = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input gtc_ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[8 +: PRESC_W] = c.presc;
    w[3] = c.ainc;
    w[2] = c.irq_en;
    w[1] = c.cmp_en;
    w[0] = c.run;
    return w;
  endfunction
endpackage

// File: rtl/gtc_prescale.sv
module gtc_prescale #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] limit,
  output logic          tick
);
  logic [PW-1:0] div_q;

  assign tick = run && (div_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (!run)    div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
  parameter int unsigned HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  output logic [2*HW-1:0] cnt
);
  localparam int unsigned NHALF = 2;

  logic [NHALF-1:0] half_wr;
  logic [NHALF-1:0] half_inc;

  assign half_wr     = {wr_hi, wr_lo};
  assign half_inc[0] = tick;
  assign half_inc[1] = tick && (&cnt[HW-1:0]);

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    logic [HW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= '0;
      else if (half_wr[g])   q <= wdata;
      else if (half_inc[g])  q <= q + 1'b1;
    end
    assign cnt[g*HW +: HW] = q;
  end
endmodule

// File: rtl/gtc_compare.sv
module gtc_compare #(
  parameter int unsigned HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_en,
  input  logic            ainc,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wr_step,
  input  logic            clr_evt,
  input  logic [HW-1:0]   wdata,
  input  logic [2*HW-1:0] cnt,
  output logic [2*HW-1:0] cmp,
  output logic [HW-1:0]   step,
  output logic            evt
);
  localparam int unsigned CW = 2 * HW;

  logic match;
  assign match = cmp_en && (cnt >= cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '0;
    end else begin
      if (match && ainc) cmp <= cmp + {{(CW-HW){1'b0}}, step};
      if (wr_lo) cmp[HW-1:0]  <= wdata;
      if (wr_hi) cmp[CW-1:HW] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= '0;
    else if (wr_step) step <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt <= 1'b0;
    else if (match)   evt <= 1'b1;
    else if (clr_evt) evt <= 1'b0;
  end
endmodule

// File: rtl/gtc_timer64.sv
module gtc_timer64
  import gtc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  gtc_ctrl_t        ctrl_q;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic [DATA_W-1:0] step;
  logic             evt;

  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;

  assign wr_cnt_lo = bus_wr && (bus_addr == OFS_CNT_LO) && !ctrl_q.run;
  assign wr_cnt_hi = bus_wr && (bus_addr == OFS_CNT_HI) && !ctrl_q.run;
  assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_stat   = bus_wr && (bus_addr == OFS_STAT) && bus_wdata[0];
  assign wr_cmp_lo = bus_wr && (bus_addr == OFS_CMP_LO);
  assign wr_cmp_hi = bus_wr && (bus_addr == OFS_CMP_HI);
  assign wr_step   = bus_wr && (bus_addr == OFS_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_unpack(bus_wdata);
  end

  gtc_prescale #(.PW(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl_q.run),
    .limit (ctrl_q.presc),
    .tick  (tick)
  );

  gtc_counter #(.HW(DATA_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_lo (wr_cnt_lo),
    .wr_hi (wr_cnt_hi),
    .wdata (bus_wdata),
    .cnt   (cnt)
  );

  gtc_compare #(.HW(DATA_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_en  (ctrl_q.cmp_en),
    .ainc    (ctrl_q.ainc),
    .wr_lo   (wr_cmp_lo),
    .wr_hi   (wr_cmp_hi),
    .wr_step (wr_step),
    .clr_evt (wr_stat),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .cmp     (cmp),
    .step    (step),
    .evt     (evt)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
      OFS_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
      OFS_CTRL:   bus_rdata = ctrl_pack(ctrl_q);
      OFS_STAT:   bus_rdata = {{(DATA_W-1){1'b0}}, evt};
      OFS_CMP_LO: bus_rdata = cmp[DATA_W-1:0];
      OFS_CMP_HI: bus_rdata = cmp[CNT_W-1:DATA_W];
      OFS_STEP:   bus_rdata = step;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = evt && ctrl_q.irq_en;
endmodule

// File: rtl/gtc_timer64_chk.sv
module gtc_timer64_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                run,
  input logic                cmp_en,
  input logic                ainc,
  input logic                irq_en,
  input logic [2*DATA_W-1:0] cnt,
  input logic [2*DATA_W-1:0] cmp,
  input logic [DATA_W-1:0]   step,
  input logic                evt,
  input logic                irq
);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bus_wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr) |=> $stable(cnt));

  p_match_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cnt >= cmp) |=> evt);

  p_auto_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && ainc && cnt >= cmp && !bus_wr) |=>
      (cmp == $past(cmp) + {{DATA_W{1'b0}}, $past(step)}));

  p_cmp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ainc && !bus_wr) |=> $stable(cmp));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind gtc_timer64 gtc_timer64_chk #(.DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .bus_wr (bus_wr),
  .run    (ctrl_q.run),
  .cmp_en (ctrl_q.cmp_en),
  .ainc   (ctrl_q.ainc),
  .irq_en (ctrl_q.irq_en),
  .cnt    (cnt),
  .cmp    (cmp),
  .step   (step),
  .evt    (evt),
  .irq    (irq)
);

// File: tb/gtc_timer64_tb_top.sv
`timescale 1ns/1ps
module gtc_timer64_tb_top;
  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_ST = 5'h0C,
                         A_MLO = 5'h10, A_MHI = 5'h14, A_STEP = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gtc_timer64 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [4:0] addrs [7] = '{A_CLO, A_CHI, A_CTL, A_ST, A_MLO, A_MHI, A_STEP};
    foreach (addrs[i]) begin
      reg_rd(addrs[i], d);
      chk("R10 reset register", d, 32'h0);
    end
    chk("R10 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    reg_wr(A_CTL, 32'hFFFF_AB0E);
    reg_rd(A_CTL, d);
    chk("R1 control fields", d, 32'h0000_AB0E);
    reg_wr(A_CTL, 32'h0);
    reg_wr(A_MLO, 32'hDEAD_0001);
    reg_wr(A_MHI, 32'h0000_00C3);
    reg_wr(A_STEP, 32'h0000_0777);
    reg_rd(A_MLO, d);  chk("R1 compare low", d, 32'hDEAD_0001);
    reg_rd(A_MHI, d);  chk("R1 compare high", d, 32'h0000_00C3);
    reg_rd(A_STEP, d); chk("R1 step", d, 32'h0000_0777);
    reg_wr(A_ST, 32'h1);
    reg_rd(A_ST, d);   chk("R6 clear flag", d, 32'h0);
  endtask

  // Runs the counter for exactly k*(p+1) enabled cycles from 'start'
  task automatic run_ticks(input logic [31:0] lo, input logic [31:0] hi,
                           input int p, input int k);
    reg_wr(A_CLO, lo);
    reg_wr(A_CHI, hi);
    reg_wr(A_CTL, (p << 8) | 32'h1);
    idle(k * (p + 1) - 2);
    reg_wr(A_CTL, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    run_ticks(32'h0, 32'h0, 3, 5);
    reg_rd(A_CLO, d); chk("R2 prescaler 3 count", d, 32'd5);
    idle(10);
    reg_rd(A_CLO, d); chk("R2 hold while stopped", d, 32'd5);
    run_ticks(32'h0, 32'h0, 0, 7);
    reg_rd(A_CLO, d); chk("R2 prescaler 0 count", d, 32'd7);
  endtask

  task automatic t_carry();
    logic [31:0] d;
    run_ticks(32'hFFFF_FFFE, 32'h5, 0, 3);
    reg_rd(A_CLO, d); chk("R3 low half after carry", d, 32'h1);
    reg_rd(A_CHI, d); chk("R3 high half after carry", d, 32'h6);
  endtask

  task automatic t_wr_running();
    logic [31:0] d;
    reg_wr(A_CLO, 32'd100);
    reg_wr(A_CHI, 32'h0);
    reg_wr(A_CTL, 32'h0000_FF01);
    reg_wr(A_CLO, 32'h0);
    reg_wr(A_CHI, 32'h9);
    reg_wr(A_CTL, 32'h0);
    reg_rd(A_CLO, d); chk("R4 low write ignored while running", d, 32'd100);
    reg_rd(A_CHI, d); chk("R4 high write ignored while running", d, 32'h0);
  endtask

  task automatic t_compare();
    logic [31:0] d;
    reg_wr(A_CLO, 32'h0); reg_wr(A_CHI, 32'h0);
    reg_wr(A_MLO, 32'd10); reg_wr(A_MHI, 32'h0);
    reg_wr(A_CTL, 32'h7);
    idle(3);
    reg_rd(A_ST, d); chk("R5 no flag before compare value", d, 32'h0);
    chk("R9 irq low before match", {31'b0, irq}, 32'h0);
    idle(20);
    reg_rd(A_ST, d); chk("R5 flag after reaching compare", d, 32'h1);
    chk("R9 irq with flag and enable", {31'b0, irq}, 32'h1);
    reg_wr(A_CTL, 32'h6);
    reg_wr(A_ST, 32'h1);
    reg_rd(A_ST, d); chk("R6 flag held while match persists", d, 32'h1);
    reg_wr(A_CTL, 32'h2);
    idle(2);
    chk("R9 irq masked when disabled", {31'b0, irq}, 32'h0);
    reg_rd(A_MLO, d); chk("R8 compare unchanged without auto-step", d, 32'd10);
    reg_wr(A_CTL, 32'h4);
    reg_wr(A_ST, 32'h1);
    idle(5);
    reg_rd(A_ST, d); chk("R5 R6 no flag without compare enable after clear", d, 32'h0);
    chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
    reg_wr(A_CTL, 32'h0);
  endtask

  task automatic t_autostep();
    logic [31:0] c, m, d;
    reg_wr(A_CLO, 32'h0); reg_wr(A_CHI, 32'h0);
    reg_wr(A_MLO, 32'd10); reg_wr(A_MHI, 32'h0);
    reg_wr(A_STEP, 32'd10);
    reg_wr(A_CTL, 32'hB);
    idle(50);
    reg_wr(A_CTL, 32'hA);
    idle(5);
    reg_rd(A_CLO, c);
    reg_rd(A_MLO, m);
    chk("R7 compare settles one step past counter", m, (c / 10 + 1) * 10);
    reg_rd(A_MHI, d); chk("R7 compare high unchanged", d, 32'h0);
    reg_rd(A_ST, d);  chk("R7 flag set by stepped match", d, 32'h1);
    reg_wr(A_ST, 32'h1);
    reg_rd(A_ST, d);  chk("R6 clear after compare moved ahead", d, 32'h0);
    reg_wr(A_CTL, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_readback();
    t_prescale();
    t_carry();
    t_wr_running();
    t_compare();
    t_autostep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule